// File: doc/BRIEF.md
# Reclocker Mode Control and Status

This block is the digital control unit of a serial video reclocker. It runs on the 27 MHz reference clock. It takes the board-level controls and the status seen from the analog clock-recovery loop. The controls are a two-bit rate selector, a forced-bypass input, an active-low mute and a secondary-output selector. The loop status is a raw PLL lock flag and a three-bit class code for the measured input rate. From these it qualifies lock and decides when the retimer is bypassed. It also gates the primary and secondary outputs, chooses whether the secondary output carries data or the recovered clock, picks single or double data rate for that clock, and drives a registered standard/high-definition indicator.

Lock is qualified by a counter on the reference clock. The raw lock and the measured rate class must stay steady and match the selected rate mode for a set number of cycles. The number of cycles is a parameter, with one value for automatic mode and one for fixed-rate mode. In a real chip these would be sized for 10–16 ms and 1–6 ms. A small output stage stands in for the differential drivers. It picks raw or retimed data and holds a muted pair at a static level.

Top module: `reclock_ctrl`

## Requirements
- R1: The rate selector acts as follows. Code 00 (automatic) accepts any supported class: 1 = SD 270 Mbps, 2 = 1.5 Gbps, 3 = 3 Gbps. Code 01 accepts only class 1. Code 10 accepts only classes 2 and 3. A class the mode does not accept never gives lock.
- R2: `lock_det` rises once raw lock, an accepted class and an unchanged class have held for LOCK_AUTO_CYC cycles (code 00) or LOCK_FIXED_CYC cycles (codes 01/10). Any loss of raw lock or change of class restarts the count, and `lock_det` falls at the next edge.
- R3: Class 0 (no valid rate, including harmonics) and classes 4–7 (143, 177, 360 and 540 Mbps) never produce lock.
- R4: While `mute_n` is low, `pri_mute` and `sec_mute` are both high, whatever the lock or bypass state.
- R5: `bypass_sel` is high when `force_bypass` is high, even while locked. With `force_bypass` low, `bypass_sel` equals the inverse of `lock_det`.
- R6: Rate code 11 is a test mode. In it `bypass_sel` is forced high, and `lock_det` is low from the next edge on.
- R7: `sec_is_clk` follows `sec_clk_sel`. When it is high, the secondary pair carries `rclk_bit`, and `sec_mute` is also high whenever `bypass_sel` is high. When it is low, the secondary pair carries the same data as the primary pair.
- R8: `clk_ddr` is high only while locked to class 3; otherwise it is low (single data rate).
- R9: `sd_flag` is registered: it is high only while locked and the class seen on the previous edge was 1. It is low whenever `lock_det` is low.
- R10: A muted pair outputs true = 0, complement = 1. An unmuted primary pair outputs `din_raw` when bypassed and `din_retimed` otherwise, with the complement inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Rate mode code (R1, R6) |
| force_bypass | input | 1 | High forces retimer bypass |
| mute_n | input | 1 | Low mutes both output pairs |
| sec_clk_sel | input | 1 | High: secondary pair carries the clock |
| pll_raw_lock | input | 1 | Unqualified lock from the analog loop |
| rate_class | input | 3 | Measured rate class code |
| din_retimed | input | 1 | Retimed data bit |
| din_raw | input | 1 | Un-retimed data bit |
| rclk_bit | input | 1 | Recovered clock level |
| lock_det | output | 1 | Qualified lock |
| bypass_sel | output | 1 | Retimer bypass select |
| pri_mute | output | 1 | Primary pair muted |
| sec_mute | output | 1 | Secondary pair muted |
| sec_is_clk | output | 1 | Secondary pair in clock mode |
| clk_ddr | output | 1 | Recovered clock is double data rate |
| sd_flag | output | 1 | Registered SD indicator |
| pri_p | output | 1 | Primary pair, true leg |
| pri_n | output | 1 | Primary pair, complement leg |
| sec_p | output | 1 | Secondary pair, true leg |
| sec_n | output | 1 | Secondary pair, complement leg |

## Verification
Qualification is run with each supported class in automatic mode, which shows the count restarting when the class changes between SD, 1.5G and 3G. The 3G case also separates the DDR clock mode from SDR. The fixed modes are each given a matching class and a mismatched class, which tells mode filtering apart from plain lock. The four unsupported classes and the test code must never lock. Toggling raw lock during a count, together with mute, forced bypass and clock-mode selection under random data, shows whether the mute override and the clock-mode mute act on the live output pairs.

// File: rtl/reclock_ctrl.sv
module reclock_ctrl #(
  parameter int LOCK_AUTO_CYC  = 40,
  parameter int LOCK_FIXED_CYC = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       force_bypass,
  input  logic       mute_n,
  input  logic       sec_clk_sel,
  input  logic       pll_raw_lock,
  input  logic [2:0] rate_class,
  input  logic       din_retimed,
  input  logic       din_raw,
  input  logic       rclk_bit,
  output logic       lock_det,
  output logic       bypass_sel,
  output logic       pri_mute,
  output logic       sec_mute,
  output logic       sec_is_clk,
  output logic       clk_ddr,
  output logic       sd_flag,
  output logic       pri_p,
  output logic       pri_n,
  output logic       sec_p,
  output logic       sec_n
);

  localparam int MAXC = (LOCK_AUTO_CYC > LOCK_FIXED_CYC) ? LOCK_AUTO_CYC : LOCK_FIXED_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [2:0]    cls_q;
  logic          sd_q;
  logic          accept;
  logic          test_mode;
  logic [CW-1:0] limit;

  assign test_mode = (rate_sel == 2'b11);
  assign limit     = (rate_sel == 2'b00) ? CW'(LOCK_AUTO_CYC) : CW'(LOCK_FIXED_CYC);

  always_comb begin
    case (rate_sel)
      2'b00:   accept = (rate_class >= 3'd1) && (rate_class <= 3'd3);
      2'b01:   accept = (rate_class == 3'd1);
      2'b10:   accept = (rate_class == 3'd2) || (rate_class == 3'd3);
      default: accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cls_q <= 3'd0;
      sd_q  <= 1'b0;
    end else begin
      cls_q <= rate_class;
      sd_q  <= (cls_q == 3'd1);
      if (!pll_raw_lock || !accept || rate_class != cls_q)
        cnt_q <= '0;
      else if (cnt_q < limit)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lock_det   = (cnt_q >= limit) && (cnt_q != '0);
  assign bypass_sel = test_mode || force_bypass || !lock_det;
  assign sec_is_clk = sec_clk_sel;
  assign pri_mute   = !mute_n;
  assign sec_mute   = !mute_n || (sec_clk_sel && bypass_sel);
  assign clk_ddr    = lock_det && (cls_q == 3'd3);
  assign sd_flag    = sd_q && lock_det;

  logic pri_bit, sec_bit;
  assign pri_bit = bypass_sel ? din_raw : din_retimed;
  assign sec_bit = sec_clk_sel ? rclk_bit : pri_bit;
  assign pri_p   = pri_mute ? 1'b0 : pri_bit;
  assign pri_n   = pri_mute ? 1'b1 : ~pri_bit;
  assign sec_p   = sec_mute ? 1'b0 : sec_bit;
  assign sec_n   = sec_mute ? 1'b1 : ~sec_bit;

  a_r4_mute_both: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |-> (pri_mute && sec_mute));
  a_r6_test_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b11) |=> !lock_det);
  a_r3_unsup_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_class >= 3'd4) |=> !lock_det);
  a_r2_rise_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_det) |-> $past(pll_raw_lock));
  a_r7_clk_bypass_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_is_clk && bypass_sel) |-> (!sec_p && sec_n));
  a_r9_sd_low_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_det |-> !sd_flag);
  a_r10_pri_static: assert property (@(posedge clk) disable iff (!rst_n)
    pri_mute |-> (!pri_p && pri_n));

endmodule

// File: tb/sim_reclock_ctrl.sv
module sim_reclock_ctrl;
  localparam int AUTO_C  = 40;
  localparam int FIXED_C = 12;

  logic clk = 0, rst_n = 0;
  logic [1:0] rate_sel = 2'b00;
  logic force_bypass = 0, mute_n = 1, sec_clk_sel = 0, pll_raw_lock = 0;
  logic [2:0] rate_class = 3'd0;
  logic din_retimed = 0, din_raw = 0, rclk_bit = 0;
  logic lock_det, bypass_sel, pri_mute, sec_mute, sec_is_clk, clk_ddr, sd_flag;
  logic pri_p, pri_n, sec_p, sec_n;

  int checks = 0, fails = 0, cycles = 0;
  int m_cnt = 0, m_cls = 0;
  bit m_sd = 0;

  reclock_ctrl #(.LOCK_AUTO_CYC(AUTO_C), .LOCK_FIXED_CYC(FIXED_C)) u0 (
    .clk, .rst_n, .rate_sel, .force_bypass, .mute_n, .sec_clk_sel, .pll_raw_lock,
    .rate_class, .din_retimed, .din_raw, .rclk_bit, .lock_det, .bypass_sel,
    .pri_mute, .sec_mute, .sec_is_clk, .clk_ddr, .sd_flag, .pri_p, .pri_n, .sec_p, .sec_n);

  always #10 clk = ~clk;

  function automatic bit accepts(int sel, int cls);
    if (sel == 0) return cls >= 1 && cls <= 3;
    if (sel == 1) return cls == 1;
    if (sel == 2) return cls == 2 || cls == 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    int lim;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_cls = 0; m_sd = 0;
    end else begin
      lim = (rate_sel == 0) ? AUTO_C : FIXED_C;
      m_sd = (m_cls == 1);
      if (!pll_raw_lock || !accepts(rate_sel, rate_class) || rate_class != m_cls) m_cnt = 0;
      else if (m_cnt < lim) m_cnt++;
      m_cls = rate_class;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_lock, e_byp, e_pm, e_sm, e_pb, e_sb;
    int lim;
    lim = (rate_sel == 0) ? AUTO_C : FIXED_C;
    e_lock = (m_cnt >= lim) && (m_cnt != 0);
    e_byp  = (rate_sel == 3) || force_bypass || !e_lock;
    e_pm   = !mute_n;
    e_sm   = !mute_n || (sec_clk_sel && e_byp);
    e_pb   = e_byp ? din_raw : din_retimed;
    e_sb   = sec_clk_sel ? rclk_bit : e_pb;
    chk(lock_det, e_lock, "R2 lock_det");
    chk(bypass_sel, e_byp, "R5 bypass_sel");
    chk(pri_mute, e_pm, "R4 pri_mute");
    chk(sec_mute, e_sm, "R7 sec_mute");
    chk(sec_is_clk, sec_clk_sel, "R7 sec_is_clk");
    chk(clk_ddr, e_lock && m_cls == 3, "R8 clk_ddr");
    chk(sd_flag, e_lock && m_sd, "R9 sd_flag");
    chk(pri_p, e_pm ? 1'b0 : e_pb, "R10 pri_p");
    chk(pri_n, e_pm ? 1'b1 : ~e_pb, "R10 pri_n");
    chk(sec_p, e_sm ? 1'b0 : e_sb, "R7 sec_p");
    chk(sec_n, e_sm ? 1'b1 : ~e_sb, "R7 sec_n");
    din_retimed = $urandom_range(0, 1);
    din_raw     = $urandom_range(0, 1);
    rclk_bit    = ~rclk_bit;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    wait_cyc(3);
    chk(lock_det, 1'b0, "R2 reset lock");
    chk(sd_flag, 1'b0, "R9 reset sd");
    rst_n = 1;
    // R1 automatic mode, SD class
    pll_raw_lock = 1; rate_class = 3'd1;
    wait_cyc(AUTO_C + 4);
    chk(lock_det, 1'b1, "R1 auto SD lock");
    chk(sd_flag, 1'b1, "R9 SD flag");
    chk(bypass_sel, 1'b0, "R5 auto no bypass");
    // R4 mute overrides
    mute_n = 0; wait_cyc(3);
    chk(pri_p, 1'b0, "R4 muted pri"); chk(sec_n, 1'b1, "R4 muted sec");
    mute_n = 1;
    // R2 class change restarts, R8 ddr
    rate_class = 3'd2; wait_cyc(2);
    chk(lock_det, 1'b0, "R2 restart on class change");
    wait_cyc(AUTO_C + 2);
    chk(clk_ddr, 1'b0, "R8 sdr at 1.5G");
    rate_class = 3'd3; wait_cyc(AUTO_C + 3);
    chk(clk_ddr, 1'b1, "R8 ddr at 3G");
    // R7 / R5 clock mode with forced bypass
    sec_clk_sel = 1; wait_cyc(4);
    force_bypass = 1; wait_cyc(4);
    chk(bypass_sel, 1'b1, "R5 forced bypass while locked");
    chk(sec_mute, 1'b1, "R7 clock mode muted in bypass");
    force_bypass = 0; sec_clk_sel = 0; wait_cyc(3);
    // R3 unsupported classes
    for (int c = 4; c < 8; c++) begin
      rate_class = c[2:0]; wait_cyc(AUTO_C + 5);
      chk(lock_det, 1'b0, "R3 unsupported class");
    end
    rate_class = 3'd0; wait_cyc(AUTO_C + 5);
    chk(lock_det, 1'b0, "R3 class 0");
    // R1 fixed modes
    rate_sel = 2'b01; rate_class = 3'd2; wait_cyc(FIXED_C + 5);
    chk(lock_det, 1'b0, "R1 fixed SD rejects HD");
    rate_class = 3'd1; wait_cyc(FIXED_C + 3);
    chk(lock_det, 1'b1, "R1 fixed SD lock");
    rate_sel = 2'b10; wait_cyc(FIXED_C + 5);
    chk(lock_det, 1'b0, "R1 fixed HD rejects SD");
    rate_class = 3'd3; wait_cyc(FIXED_C + 3);
    chk(lock_det, 1'b1, "R1 fixed HD lock");
    // R6 test code
    rate_sel = 2'b11; wait_cyc(2);
    chk(lock_det, 1'b0, "R6 test no lock");
    chk(bypass_sel, 1'b1, "R6 test bypass");
    // R2 raw lock drop mid count
    rate_sel = 2'b00; rate_class = 3'd2; wait_cyc(AUTO_C / 2);
    pll_raw_lock = 0; wait_cyc(1); pll_raw_lock = 1;
    wait_cyc(AUTO_C / 2 + 2);
    chk(lock_det, 1'b0, "R2 raw drop restarts");
    wait_cyc(AUTO_C);
    chk(lock_det, 1'b1, "R2 relock");
    wait_cyc(5);
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule